// File: doc/BRIEF.md
# Paced Descriptor Accumulator Channel

This block is a single accumulator channel that sits between a hardware queue manager and a host. It watches a window of contiguous queues, walks that window one queue per cycle, and issues a pop request to each queue in turn. Every pop that returns a descriptor has its address written into a host-owned list buffer, at the next free slot. The channel keeps a count of the slots it has filled.

The host is told to read the list through a level interrupt. The interrupt is raised for one of two reasons. The first is that the list has reached its programmed capacity. The second is that a pacing timer, clocked by a one-microsecond tick, has reached the programmed latency while the list holds at least one entry. The pacing mode selects the event that starts this timer, or turns the timer off. Once the interrupt is raised, the list is frozen until the host acknowledges it. The acknowledge empties the list.

Top module: `pacedAccumulator`

## Requirements
- R1: While reset is held, and on release, the interrupt is low, the entry count is 0, and neither a pop request nor a list write is made.
- R2: A pop goes to queue cfgBase + offset. The offset starts at 0, moves up by one on every pop issued, and wraps to 0 after cfgQueueCount queues (1 to 32). The offset returns to 0 while cfgEnable is low. Descriptors of one queue reach the list in the order they were queued.
- R3: One pop is issued in every cycle in which the channel is enabled, the interrupt is low and the entry count is below cfgListDepth.
- R4: A pop that returns a descriptor (popHit high in the same cycle) writes popDesc to list slot entryCount in that cycle, and the count rises by one on the next edge.
- R5: The interrupt rises on the edge after the entry count reaches cfgListDepth.
- R6: cfgPaceMode = 0 disables the timer, so the interrupt is raised only by a full list, however many ticks arrive.
- R7: cfgPaceMode = 1 counts ticks from the edge on which the previous interrupt was raised. The count continues while the list is frozen. The interrupt fires once cfgLatency ticks have been counted and the list is not empty.
- R8: cfgPaceMode = 2 starts counting ticks at the first descriptor written after an interrupt. Later writes do not restart the count.
- R9: cfgPaceMode = 3 restarts the tick count on every descriptor written, so the interrupt follows cfgLatency ticks with no new descriptor.
- R10: Once raised, the interrupt stays high until irqAck. While it is high, no pop is issued and the list is left untouched.
- R11: irqAck while the interrupt is high drops the interrupt and clears the entry count on the same edge. irqAck while the interrupt is low has no effect.
- R12: entryCount always shows the number of valid list entries, so the host can read it when the interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Channel enable; low holds the poll offset at 0 |
| cfgBase | input | QID_W | First queue of the monitored window |
| cfgQueueCount | input | QCNT_W | Number of monitored queues, 1 to MAX_QUEUES |
| cfgListDepth | input | CNT_W | List capacity in entries, 1 to MAX_DEPTH |
| cfgPaceMode | input | 2 | 0 off, 1 since interrupt, 2 since first new, 3 since last new |
| cfgLatency | input | LAT_W | Pacing delay in microsecond ticks |
| usTick | input | 1 | One-cycle pulse per microsecond |
| popReq | output | 1 | Pop request to the queue manager |
| popQid | output | QID_W | Queue addressed by the pop |
| popHit | input | 1 | Same-cycle reply: the queue returned a descriptor |
| popDesc | input | DESC_W | Descriptor address returned by the pop |
| listWe | output | 1 | List buffer write strobe |
| listAddr | output | CNT_W | List slot written |
| listData | output | DESC_W | Descriptor address written |
| irq | output | 1 | Host interrupt, level |
| irqAck | input | 1 | Host acknowledge; empties the list |
| entryCount | output | CNT_W | Valid list entries |

## Verification
The assertions rely on a few assumptions about the inputs. cfgQueueCount and cfgListDepth are never zero. The configuration changes only while the channel is disabled and the list is empty. The queue manager answers a pop in the same cycle it is issued. The bench keeps to these assumptions. Each round first drops cfgEnable and acknowledges the list, and only then writes a new configuration. Random values are drawn from legal ranges, with base plus window kept inside the queue model. Pops are answered combinationally from per-queue FIFO counters.

// File: rtl/accPkg.sv
package accPkg;

  typedef enum logic [1:0] {
    PACE_OFF         = 2'd0,
    PACE_SINCE_IRQ   = 2'd1,
    PACE_SINCE_FIRST = 2'd2,
    PACE_SINCE_LAST  = 2'd3
  } paceMode_t;

  // strobes from control to datapath, all valid for the current cycle
  typedef struct packed {
    logic issuePop;
    logic storeEntry;
    logic raiseIrq;
    logic clearList;
    logic clearPtr;
  } accStrobe_t;

endpackage

// File: rtl/accDatapath.sv
module accDatapath
  import accPkg::*;
#(
  parameter int QID_W      = 8,
  parameter int DESC_W     = 16,
  parameter int MAX_QUEUES = 32,
  parameter int MAX_DEPTH  = 64,
  parameter int LAT_W      = 12,
  localparam int OFF_W     = $clog2(MAX_QUEUES),
  localparam int QCNT_W    = OFF_W + 1,
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic [QID_W-1:0]  cfgBase,
  input  logic [QCNT_W-1:0] cfgQueueCount,
  input  logic [CNT_W-1:0]  cfgListDepth,
  input  paceMode_t         cfgMode,
  input  logic [LAT_W-1:0]  cfgLatency,
  input  logic              usTick,
  input  logic [DESC_W-1:0] popDesc,
  output logic [QID_W-1:0]  popQid,
  output logic [CNT_W-1:0]  listAddr,
  output logic [DESC_W-1:0] listData,
  output logic [CNT_W-1:0]  entryCount,
  output logic              timerDue
);

  logic [OFF_W-1:0] pollOffset;
  logic [CNT_W-1:0] fillCount;
  logic [LAT_W-1:0] paceTimer;
  logic             paceArmed;
  logic             offsetWrap;
  logic             timerArmed;
  logic             timerAtLimit;

  // round-robin poll offset inside the monitored window
  assign offsetWrap = ({1'b0, pollOffset} + QCNT_W'(1)) >= cfgQueueCount;

  always_ff @(posedge clk) begin
    if (!rstN)                pollOffset <= '0;
    else if (strobe.clearPtr) pollOffset <= '0;
    else if (strobe.issuePop) pollOffset <= offsetWrap ? '0 : pollOffset + OFF_W'(1);
  end

  assign popQid = cfgBase + QID_W'(pollOffset);

  // list fill counter doubles as the write slot
  always_ff @(posedge clk) begin
    if (!rstN)                  fillCount <= '0;
    else if (strobe.clearList)  fillCount <= '0;
    else if (strobe.storeEntry) fillCount <= fillCount + CNT_W'(1);
  end

  assign listAddr   = fillCount;
  assign listData   = popDesc;
  assign entryCount = fillCount;

  // pacing timer: the mode picks which event restarts it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      paceTimer <= '0;
      paceArmed <= 1'b0;
    end else if (strobe.raiseIrq) begin
      paceTimer <= '0;
      paceArmed <= 1'b0;
    end else if (strobe.storeEntry && cfgMode == PACE_SINCE_FIRST && !paceArmed) begin
      paceTimer <= '0;
      paceArmed <= 1'b1;
    end else if (strobe.storeEntry && cfgMode == PACE_SINCE_LAST) begin
      paceTimer <= '0;
      paceArmed <= 1'b1;
    end else if (usTick && paceTimer < cfgLatency) begin
      paceTimer <= paceTimer + LAT_W'(1);
    end
  end

  assign timerArmed   = (cfgMode == PACE_SINCE_IRQ) || paceArmed;
  assign timerAtLimit = paceTimer >= cfgLatency;
  assign timerDue     = (cfgMode != PACE_OFF) && timerArmed && timerAtLimit
                        && (fillCount != '0);

  // ---------------- assertions ----------------
  logic [QID_W-1:0] qidOffset;
  assign qidOffset = popQid - cfgBase;

  p_qid_in_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issuePop |-> (qidOffset < QID_W'(cfgQueueCount)));

  p_store_bumps_count_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeEntry |=> (entryCount == $past(entryCount) + CNT_W'(1)));

  p_count_in_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    entryCount <= cfgListDepth);

endmodule

// File: rtl/accControl.sv
module accControl
  import accPkg::*;
#(
  parameter int MAX_DEPTH = 64,
  localparam int CNT_W    = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  paceMode_t        cfgMode,
  input  logic [CNT_W-1:0] cfgListDepth,
  input  logic [CNT_W-1:0] entryCount,
  input  logic             timerDue,
  input  logic             popHit,
  input  logic             irqAck,
  output accStrobe_t       strobe,
  output logic             irq
);

  logic irqReg;
  logic listFull;

  assign listFull = entryCount >= cfgListDepth;

  always_comb begin
    strobe            = '0;
    strobe.issuePop   = cfgEnable && !irqReg && !listFull;
    strobe.storeEntry = strobe.issuePop && popHit;
    strobe.raiseIrq   = !irqReg && (listFull || timerDue);
    strobe.clearList  = irqReg && irqAck;
    strobe.clearPtr   = !cfgEnable;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 irqReg <= 1'b0;
    else if (strobe.raiseIrq)  irqReg <= 1'b1;
    else if (strobe.clearList) irqReg <= 1'b0;
  end

  assign irq = irqReg;

  // ---------------- assertions ----------------
  p_irq_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReg && !irqAck) |=> irqReg);

  p_ack_empties_r11: assert property (@(posedge clk) disable iff (!rstN)
    (irqReg && irqAck) |=> (!irqReg && entryCount == '0));

  p_mode_off_full_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqReg) && cfgMode == PACE_OFF) |-> (entryCount >= cfgListDepth));

  p_full_raises_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReg && entryCount >= cfgListDepth) |=> irqReg);

endmodule

// File: rtl/pacedAccumulator.sv
module pacedAccumulator
  import accPkg::*;
#(
  parameter int QID_W      = 8,
  parameter int DESC_W     = 16,
  parameter int MAX_QUEUES = 32,
  parameter int MAX_DEPTH  = 64,
  parameter int LAT_W      = 12,
  localparam int QCNT_W    = $clog2(MAX_QUEUES) + 1,
  localparam int CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [QID_W-1:0]  cfgBase,
  input  logic [QCNT_W-1:0] cfgQueueCount,
  input  logic [CNT_W-1:0]  cfgListDepth,
  input  logic [1:0]        cfgPaceMode,
  input  logic [LAT_W-1:0]  cfgLatency,
  input  logic              usTick,
  output logic              popReq,
  output logic [QID_W-1:0]  popQid,
  input  logic              popHit,
  input  logic [DESC_W-1:0] popDesc,
  output logic              listWe,
  output logic [CNT_W-1:0]  listAddr,
  output logic [DESC_W-1:0] listData,
  output logic              irq,
  input  logic              irqAck,
  output logic [CNT_W-1:0]  entryCount
);

  accStrobe_t strobe;
  paceMode_t  paceMode;
  logic       timerDue;

  assign paceMode = paceMode_t'(cfgPaceMode);

  accControl #(.MAX_DEPTH(MAX_DEPTH)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .cfgMode      (paceMode),
    .cfgListDepth (cfgListDepth),
    .entryCount   (entryCount),
    .timerDue     (timerDue),
    .popHit       (popHit),
    .irqAck       (irqAck),
    .strobe       (strobe),
    .irq          (irq)
  );

  accDatapath #(
    .QID_W      (QID_W),
    .DESC_W     (DESC_W),
    .MAX_QUEUES (MAX_QUEUES),
    .MAX_DEPTH  (MAX_DEPTH),
    .LAT_W      (LAT_W)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cfgBase       (cfgBase),
    .cfgQueueCount (cfgQueueCount),
    .cfgListDepth  (cfgListDepth),
    .cfgMode       (paceMode),
    .cfgLatency    (cfgLatency),
    .usTick        (usTick),
    .popDesc       (popDesc),
    .popQid        (popQid),
    .listAddr      (listAddr),
    .listData      (listData),
    .entryCount    (entryCount),
    .timerDue      (timerDue)
  );

  assign popReq = strobe.issuePop;
  assign listWe = strobe.storeEntry;

  p_frozen_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!popReq && !listWe));

endmodule

// File: tb/sim_pacedAccumulator.sv
`timescale 1ns/1ps
module sim_pacedAccumulator;

  localparam int QID_W = 8, DESC_W = 16, CNT_W = 7, QCNT_W = 6, LAT_W = 12;
  localparam int NQ = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0;
  logic [QID_W-1:0]  cfgBase = '0;
  logic [QCNT_W-1:0] cfgQueueCount = 6'd1;
  logic [CNT_W-1:0]  cfgListDepth = 7'd1;
  logic [1:0]        cfgPaceMode = 2'd0;
  logic [LAT_W-1:0]  cfgLatency = '0;
  logic usTick = 1'b0;
  logic irqAck = 1'b0;
  logic popReq, popHit, listWe, irq;
  logic [QID_W-1:0]  popQid;
  logic [DESC_W-1:0] popDesc, listData;
  logic [CNT_W-1:0]  listAddr, entryCount;

  int qHead [NQ];
  int qTail [NQ];
  logic [DESC_W-1:0] hostList [64];

  int checks = 0;
  int fails = 0;
  int expPtr = 0;
  int expCount = 0;
  logic prevIrq = 1'b0;

  always #5 clk = ~clk;

  pacedAccumulator u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgBase(cfgBase),
    .cfgQueueCount(cfgQueueCount), .cfgListDepth(cfgListDepth),
    .cfgPaceMode(cfgPaceMode), .cfgLatency(cfgLatency), .usTick(usTick),
    .popReq(popReq), .popQid(popQid), .popHit(popHit), .popDesc(popDesc),
    .listWe(listWe), .listAddr(listAddr), .listData(listData),
    .irq(irq), .irqAck(irqAck), .entryCount(entryCount)
  );

  // queue manager model: per-queue FIFO of sequence numbers
  assign popHit  = popReq && (qHead[popQid] != qTail[popQid]);
  assign popDesc = {popQid, 8'(qHead[popQid])};

  always @(posedge clk) begin
    if (popReq && popHit) qHead[popQid] <= qHead[popQid] + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int nextOffset(int p, int qc);
    return (p + 1 >= qc) ? 0 : p + 1;
  endfunction

  // per-cycle monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      expPtr = 0; expCount = 0; prevIrq = 1'b0;
    end else begin
      automatic bit expIssue = cfgEnable && !irq && (expCount < int'(cfgListDepth));
      chk(entryCount == CNT_W'(expCount), "R12", "entry count", entryCount, expCount);
      chk(popReq == expIssue, "R3", "pop issue", popReq, expIssue);
      if (irq && !prevIrq)
        chk((expCount >= int'(cfgListDepth)) || (cfgPaceMode != 0), "R5",
            "irq cause", expCount, cfgListDepth);
      if (popReq) begin
        chk(popQid == QID_W'(int'(cfgBase) + expPtr), "R2", "poll queue",
            popQid, int'(cfgBase) + expPtr);
        if (popHit) begin
          chk(listWe && listAddr == CNT_W'(expCount) && listData == popDesc, "R4",
              "list write slot", listAddr, expCount);
          hostList[expCount] = listData;
          expCount++;
        end
        expPtr = nextOffset(expPtr, int'(cfgQueueCount));
      end else begin
        chk(!listWe, "R4", "write without pop", listWe, 0);
      end
      if (irq && irqAck) expCount = 0;
      if (!cfgEnable) expPtr = 0;
      prevIrq = irq;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic push(input int q, input int n);
    qTail[q] = qTail[q] + n;
  endtask

  task automatic tick();
    usTick = 1'b1; cyc(1);
    usTick = 1'b0; cyc(1);
  endtask

  task automatic ack();
    irqAck = 1'b1; cyc(1);
    irqAck = 1'b0;
  endtask

  task automatic setCfg(input int base, input int qc, input int depth,
                        input int mode, input int lat);
    cfgEnable = 1'b0; cyc(2);
    cfgBase = QID_W'(base); cfgQueueCount = QCNT_W'(qc);
    cfgListDepth = CNT_W'(depth); cfgPaceMode = 2'(mode);
    cfgLatency = LAT_W'(lat);
    cfgEnable = 1'b1;
  endtask

  int cycleCount = 0;
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cycleCount, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1971));
    for (int i = 0; i < NQ; i++) begin qHead[i] = 0; qTail[i] = 0; end
    cyc(5);
    chk(irq == 0 && entryCount == 0 && popReq == 0 && listWe == 0, "R1",
        "outputs in reset", {irq, popReq, listWe}, 0);
    rstN = 1'b1; cyc(1);
    chk(irq == 0 && entryCount == 0, "R1", "after release", entryCount, 0);

    // R2/R5: window of four queues, two descriptors each, mode off
    setCfg(8, 4, 8, 0, 5);
    for (int q = 8; q < 12; q++) push(q, 2);
    cyc(15);
    chk(irq == 1, "R5", "full raises irq", irq, 1);
    chk(entryCount == 8, "R5", "count at full", entryCount, 8);
    for (int i = 0; i < 8; i++)
      chk(hostList[i] == {8'(8 + i % 4), 8'(i / 4)}, "R2", "list order",
          hostList[i], {8'(8 + i % 4), 8'(i / 4)});

    // R10: frozen list ignores new descriptors
    push(8, 3);
    cyc(10);
    chk(entryCount == 8 && irq == 1, "R10", "frozen count", entryCount, 8);
    chk(qHead[8] == 2, "R10", "no pop while frozen", qHead[8], 2);

    // R11: ack empties the list on the same edge
    ack();
    chk(irq == 0 && entryCount == 0, "R11", "ack clears", entryCount, 0);

    // R6: mode off ignores ticks
    for (int i = 0; i < 12; i++) tick();
    chk(irq == 0, "R6", "no timer irq in mode 0", irq, 0);
    chk(entryCount == 3, "R6", "partial list kept", entryCount, 3);

    // R11: ack with irq low is ignored
    ack(); cyc(1);
    chk(entryCount == 3 && irq == 0, "R11", "stray ack ignored", entryCount, 3);

    // R7: mode 1 with zero latency fires on a non-empty list at once
    setCfg(8, 4, 8, 1, 0);
    cyc(3);
    chk(irq == 1, "R7", "zero latency fires", irq, 1);
    ack();

    // R7: time measured from the previous interrupt
    setCfg(20, 1, 2, 1, 3);
    push(20, 2);
    cyc(5);
    chk(irq == 1 && entryCount == 2, "R5", "small list full", entryCount, 2);
    for (int i = 0; i < 3; i++) tick();
    ack();
    push(20, 1);
    cyc(4);
    chk(irq == 1, "R7", "delay already elapsed while frozen", irq, 1);
    ack();
    push(20, 1);
    cyc(6);
    chk(irq == 0, "R7", "no ticks since irq", irq, 0);
    tick(); tick();
    chk(irq == 0, "R7", "two of three ticks", irq, 0);
    tick();
    chk(irq == 1, "R7", "third tick fires", irq, 1);
    ack();

    // R8: delay from first new descriptor, not restarted
    setCfg(20, 1, 8, 2, 3);
    push(20, 1); cyc(3);
    tick(); tick();
    chk(irq == 0, "R8", "two ticks after first", irq, 0);
    push(20, 1); cyc(3);
    chk(irq == 0 && entryCount == 2, "R8", "second entry stored", entryCount, 2);
    tick();
    chk(irq == 1, "R8", "fires on third tick since first", irq, 1);
    ack();

    // R9: delay restarted by every new descriptor
    setCfg(20, 1, 8, 3, 3);
    push(20, 1); cyc(3);
    tick(); tick();
    push(20, 1); cyc(3);
    tick();
    chk(irq == 0, "R9", "restart by second entry", irq, 0);
    tick();
    chk(irq == 0, "R9", "two ticks since last", irq, 0);
    tick();
    chk(irq == 1 && entryCount == 2, "R9", "third tick since last fires", irq, 1);
    ack();

    // random rounds: R2 R3 R4 R5 across windows, depths and modes
    for (int r = 0; r < 30; r++) begin
      automatic int base  = $urandom_range(0, 31);
      automatic int qc    = $urandom_range(1, 32);
      automatic int depth = $urandom_range(1, 16);
      automatic int mode  = $urandom_range(0, 3);
      automatic int lat   = $urandom_range(0, 6);
      setCfg(base, qc, depth, mode, lat);
      for (int k = 0; k < depth; k++) push(base + $urandom_range(0, qc - 1), 1);
      for (int c = 0; c < 3000 && !irq; c++) begin
        usTick = ($urandom_range(0, 2) == 0);
        cyc(1);
      end
      usTick = 1'b0;
      chk(irq == 1, "R5", "random round interrupt", irq, 1);
      chk(entryCount >= 1 && entryCount <= CNT_W'(depth), "R12", "random count bound",
          entryCount, depth);
      for (int i = 0; i < int'(entryCount); i++)
        chk(int'(hostList[i][15:8]) >= base && int'(hostList[i][15:8]) < base + qc,
            "R2", "entry from window", hostList[i][15:8], base);
      irqAck = 1'b1; cfgEnable = 1'b0; cyc(1);
      irqAck = 1'b0; cyc(1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule